// File: doc/BRIEF.md
# Binary-Spike Integrate-and-Fire Neuron Core

This block is the arithmetic heart of one neuron in a spiking convolution layer. Each clock it accepts a beat of eight binary input spikes with eight signed 8-bit synaptic weights. A weight passes into the sum only when its spike is present. The eight gated weights are reduced by a pipelined binary adder tree, and the beat total is integrated into a membrane accumulator. When the beat flagged as the last of the kernel arrives, the integrated potential is compared against that neuron's trained threshold and a single output spike is produced.

Gating uses no logic gate. Each weight is captured in a register whose synchronous clear is driven by the absent spike, and those registers double as the retiming stage in front of the tree. A beat-enable bit travels through the pipeline with the data. A separate valid output marks the one cycle in which the neuron's decision is ready. The latency from a last beat at the input to that valid output is fixed at 5 clock cycles: 1 gating stage, 3 tree stages and 1 integrate-and-compare stage.

A controller upstream presents beats with `first_i`/`last_i` framing. `thresh_i` is sampled together with the last beat.

Top module: `spike_if_core`

## Requirements
- R1: Weight lane k occupies `weights_i[8k+7:8k]` and is paired with `spikes_i[k]`. A lane contributes its weight to the beat sum only when its spike bit is 1, and contributes 0 otherwise.
- R2: The beat sum is the exact signed two's-complement sum of the contributing 8-bit weights.
- R3: A valid beat with `first_i`=1 loads the accumulator with its beat sum. Every other valid beat adds its beat sum to the accumulator.
- R4: The output spike is 1 only when the accumulated potential, including the last beat, is strictly greater than `thresh_i`. Equality gives 0.
- R5: `fire_vld_o` is high for exactly one cycle, 5 clock cycles after a beat with `beat_en_i`=1 and `last_i`=1 is presented, and is low at all other times.
- R6: A beat with `beat_en_i`=0 has no effect on the accumulator or the outputs, whatever its spikes, weights and flags.
- R7: `fire_o` is 0 whenever `fire_vld_o` is 0.
- R8: While `rst_ni` is low, `fire_o` and `fire_vld_o` are 0 and the pipeline is cleared.
- R9: A new neuron started with `first_i` discards the previous neuron's potential, so back-to-back neurons are independent.
- R10: Weights and thresholds are signed. The 20-bit accumulator holds a kernel of up to 512 beats at full-scale weights without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| beat_en_i | input | 1 | Beat valid |
| first_i | input | 1 | Beat is the first of a neuron's kernel |
| last_i | input | 1 | Beat is the last of a neuron's kernel |
| spikes_i | input | 8 | Input spikes, one per lane |
| weights_i | input | 64 | Eight signed 8-bit weights, lane k at bits 8k+7:8k |
| thresh_i | input | 20 | Signed firing threshold, sampled with the last beat |
| fire_o | output | 1 | Output spike |
| fire_vld_o | output | 1 | Output spike valid |

## Verification
On every cycle, the assertions check four things: the gating registers hold exactly the spiked weights of the previous beat, the tree output equals the sum of the gated lanes three cycles earlier, the accumulator holds still after a disabled beat, and the valid output tracks enabled last beats at the fixed latency while the spike stays quiet outside it. The strict threshold comparison can only be shown by the bench's scenarios, because it depends on the accumulated history of a whole kernel. The same holds for the first-beat reload between neighbouring neurons, for signed extremes, and for a 512-beat full-scale kernel.

// File: rtl/sif_pkg.sv
package sif_pkg;
  localparam int unsigned LANES_DEF = 8;
  localparam int unsigned WGT_W_DEF = 8;
  localparam int unsigned ACC_W_DEF = 20;

  typedef struct packed {
    logic en;
    logic first;
    logic last;
  } beat_ctl_t;
endpackage

// File: rtl/sif_gate.sv
// Weight capture with spike-driven synchronous clear; also the retiming stage.
module sif_gate #(
  parameter int unsigned LANES = 8,
  parameter int unsigned WGT_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [LANES-1:0]       spikes_i,
  input  logic [LANES*WGT_W-1:0] weights_i,
  output logic [LANES*WGT_W-1:0] gated_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          gated_o[k*WGT_W +: WGT_W] <= '0;
      else if (!spikes_i[k]) gated_o[k*WGT_W +: WGT_W] <= '0;
      else                  gated_o[k*WGT_W +: WGT_W] <= weights_i[k*WGT_W +: WGT_W];
    end
  end
endmodule

// File: rtl/sif_adder_tree.sv
// Heap-indexed pipelined reduction: one register stage per tree level.
module sif_adder_tree #(
  parameter int unsigned LANES = 8,
  parameter int unsigned WGT_W = 8,
  localparam int unsigned LEVELS = $clog2(LANES),
  localparam int unsigned SUM_W  = WGT_W + LEVELS
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [LANES*WGT_W-1:0]  lanes_i,
  output logic signed [SUM_W-1:0] sum_o
);
  localparam int unsigned NODES = LANES - 1;

  logic signed [SUM_W-1:0] leaf   [LANES];
  logic signed [SUM_W-1:0] node_q [NODES];

  for (genvar k = 0; k < LANES; k++) begin : g_leaf
    assign leaf[k] = {{LEVELS{lanes_i[(k+1)*WGT_W-1]}}, lanes_i[k*WGT_W +: WGT_W]};
  end

  for (genvar i = 0; i < NODES; i++) begin : g_node
    localparam int unsigned CL = 2*i + 1;
    localparam int unsigned CR = 2*i + 2;
    logic signed [SUM_W-1:0] a, b;
    if (CL >= NODES) begin : g_la
      assign a = leaf[CL-NODES];
    end else begin : g_na
      assign a = node_q[CL];
    end
    if (CR >= NODES) begin : g_lb
      assign b = leaf[CR-NODES];
    end else begin : g_nb
      assign b = node_q[CR];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) node_q[i] <= '0;
      else         node_q[i] <= a + b;
    end
  end

  assign sum_o = node_q[0];
endmodule

// File: rtl/sif_pipe.sv
module sif_pipe #(
  parameter int unsigned W     = 1,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < DEPTH; j++) st_q[j] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int j = 1; j < DEPTH; j++) st_q[j] <= st_q[j-1];
    end
  end

  assign q_o = st_q[DEPTH-1];
endmodule

// File: rtl/sif_accum.sv
module sif_accum
  import sif_pkg::*;
#(
  parameter int unsigned SUM_W = 11,
  parameter int unsigned ACC_W = 20
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  beat_ctl_t               ctl_i,
  input  logic signed [ACC_W-1:0] thr_i,
  input  logic signed [SUM_W-1:0] sum_i,
  output logic signed [ACC_W-1:0] acc_o,
  output logic                    fire_o,
  output logic                    fire_vld_o
);
  logic signed [ACC_W-1:0] sum_ext, acc_nxt;

  assign sum_ext = {{(ACC_W-SUM_W){sum_i[SUM_W-1]}}, sum_i};
  assign acc_nxt = ctl_i.first ? sum_ext : acc_o + sum_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o      <= '0;
      fire_o     <= 1'b0;
      fire_vld_o <= 1'b0;
    end else begin
      if (ctl_i.en) acc_o <= acc_nxt;
      fire_vld_o <= ctl_i.en & ctl_i.last;
      fire_o     <= ctl_i.en & ctl_i.last & (acc_nxt > thr_i);
    end
  end
endmodule

// File: rtl/spike_if_core.sv
module spike_if_core
  import sif_pkg::*;
#(
  parameter int unsigned LANES = LANES_DEF,
  parameter int unsigned WGT_W = WGT_W_DEF,
  parameter int unsigned ACC_W = ACC_W_DEF
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   beat_en_i,
  input  logic                   first_i,
  input  logic                   last_i,
  input  logic [LANES-1:0]       spikes_i,
  input  logic [LANES*WGT_W-1:0] weights_i,
  input  logic [ACC_W-1:0]       thresh_i,
  output logic                   fire_o,
  output logic                   fire_vld_o
);
  localparam int unsigned LEVELS = $clog2(LANES);
  localparam int unsigned SUM_W  = WGT_W + LEVELS;
  localparam int unsigned SIDE_W = $bits(beat_ctl_t) + ACC_W;
  localparam int unsigned SIDE_D = 1 + LEVELS;  // gate stage + tree stages

  logic [LANES*WGT_W-1:0]  gated;
  logic signed [SUM_W-1:0] tree_sum;
  logic signed [ACC_W-1:0] acc_q;
  beat_ctl_t               ctl_in, ctl_d;
  logic [ACC_W-1:0]        thr_d;

  assign ctl_in = '{en: beat_en_i, first: first_i, last: last_i};

  sif_gate #(.LANES(LANES), .WGT_W(WGT_W)) u_gate (
    .clk_i, .rst_ni, .spikes_i, .weights_i, .gated_o(gated)
  );

  sif_adder_tree #(.LANES(LANES), .WGT_W(WGT_W)) u_tree (
    .clk_i, .rst_ni, .lanes_i(gated), .sum_o(tree_sum)
  );

  sif_pipe #(.W(SIDE_W), .DEPTH(SIDE_D)) u_side (
    .clk_i, .rst_ni, .d_i({ctl_in, thresh_i}), .q_o({ctl_d, thr_d})
  );

  sif_accum #(.SUM_W(SUM_W), .ACC_W(ACC_W)) u_acc (
    .clk_i, .rst_ni, .ctl_i(ctl_d), .thr_i(signed'(thr_d)), .sum_i(tree_sum),
    .acc_o(acc_q), .fire_o, .fire_vld_o
  );
endmodule

// File: rtl/sif_core_chk.sv
module sif_core_chk #(
  parameter int unsigned LANES = 8,
  parameter int unsigned WGT_W = 8,
  parameter int unsigned ACC_W = 20,
  localparam int unsigned SUM_W = WGT_W + $clog2(LANES)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    beat_en_i,
  input logic                    last_i,
  input logic [LANES-1:0]        spikes_i,
  input logic [LANES*WGT_W-1:0]  weights_i,
  input logic [LANES*WGT_W-1:0]  gated_i,
  input logic signed [SUM_W-1:0] sum_i,
  input logic signed [ACC_W-1:0] acc_i,
  input logic                    fire_o,
  input logic                    fire_vld_o
);
  logic [3:0]              cyc;
  logic [LANES*WGT_W-1:0]  sp_mask;
  logic signed [SUM_W-1:0] gsum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cyc <= '0;
    else if (cyc != 4'hf) cyc <= cyc + 4'd1;
  end

  always_comb begin
    gsum = '0;
    for (int k = 0; k < LANES; k++) begin
      sp_mask[k*WGT_W +: WGT_W] = {WGT_W{spikes_i[k]}};
      gsum = gsum + SUM_W'(signed'(gated_i[k*WGT_W +: WGT_W]));
    end
  end

  p_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 4'd2) |-> gated_i == ($past(weights_i) & $past(sp_mask)));

  p_tree_sum_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 4'd4) |-> sum_i == $past(gsum, 3));

  p_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 4'd6) |-> fire_vld_o == $past(beat_en_i && last_i, 5));

  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 4'd7) && !$past(beat_en_i, 5) |-> $stable(acc_i));

  p_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_vld_o |-> !fire_o);

  always_comb begin
    if (!rst_ni) begin
      a_reset_r8: assert (!fire_vld_o && !fire_o);
    end
  end
endmodule

bind spike_if_core sif_core_chk #(.LANES(LANES), .WGT_W(WGT_W), .ACC_W(ACC_W)) u_chk (
  .clk_i, .rst_ni, .beat_en_i, .last_i, .spikes_i, .weights_i,
  .gated_i(gated), .sum_i(tree_sum), .acc_i(acc_q), .fire_o, .fire_vld_o
);

// File: tb/spike_if_core_test.sv
`timescale 1ns/1ps
module spike_if_core_test;
  localparam int LAT = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, first = 1'b0, last = 1'b0;
  logic [7:0]  spk = '0;
  logic [63:0] wb = '0;
  logic [19:0] thr = '0;
  logic        fire, fire_vld;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0, mon_on = 0;
  int    due_q[$];
  bit    exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spike_if_core uut (
    .clk_i(clk), .rst_ni(rst_n), .beat_en_i(en), .first_i(first), .last_i(last),
    .spikes_i(spk), .weights_i(wb), .thresh_i(thr), .fire_o(fire), .fire_vld_o(fire_vld)
  );

  function automatic int beat_sum(logic [7:0] s, logic [63:0] w);
    int t = 0;
    for (int k = 0; k < 8; k++) if (s[k]) t += int'($signed(w[8*k +: 8]));
    return t;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic drive(bit e, bit f, bit l, logic [7:0] s, logic [63:0] w, int t,
                       bit exp_fire, string tag);
    @(negedge clk);
    en = e; first = f; last = l; spk = s; wb = w; thr = t[19:0];
    if (e && l) begin
      due_q.push_back(cyc + LAT);
      exp_q.push_back(exp_fire);
      tag_q.push_back(tag);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 8'h00, 64'h0, 0, 0, "");
  endtask

  // nb identical beats; threshold given with last beat
  task automatic fixed_neuron(int nb, logic [7:0] s, logic [63:0] w, int t, string tag);
    int tot = nb * beat_sum(s, w);
    for (int b = 0; b < nb; b++)
      drive(1, b == 0, b == nb-1, s, w, t, tot > t, tag);
  endtask

  task automatic rand_neuron(int nb, bit bubbles);
    int tot = 0;
    for (int b = 0; b < nb; b++) begin
      logic [7:0]  s = 8'($urandom);
      logic [63:0] w = {$urandom, $urandom};
      int t;
      if (bubbles && ($urandom % 4 == 0))  // R6: disabled beat with live flags and data
        drive(0, 1, 1, 8'hff, {$urandom, $urandom}, 0, 0, "");
      tot += beat_sum(s, w);
      t = tot + int'($urandom % 7) - 3;
      drive(1, b == 0, b == nb-1, s, w, t, tot > t, bubbles ? "R6" : "R3");
    end
  endtask

  // Output monitor: R5 timing, R4/R3 value, R7 quiet spike
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (due_q.size() != 0 && due_q[0] == cyc) begin
        check(fire_vld == 1'b1, "R5", "valid at due cycle", int'(fire_vld), 1);
        check(fire == exp_q[0], tag_q[0], "output spike", int'(fire), int'(exp_q[0]));
        void'(due_q.pop_front()); void'(exp_q.pop_front()); void'(tag_q.pop_front());
      end else begin
        check(fire_vld == 1'b0, "R5", "valid outside due cycle", int'(fire_vld), 0);
        check(fire == 1'b0, "R7", "spike without valid", int'(fire), 0);
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(fire_vld == 0, "R8", "valid in reset", int'(fire_vld), 0);
    check(fire == 0, "R8", "spike in reset", int'(fire), 0);
    @(negedge clk); rst_n = 1'b1; mon_on = 1;
    idle(2);

    // R4: equal does not fire, one below fires
    fixed_neuron(1, 8'hff, {8{8'd10}}, 80, "R4");
    fixed_neuron(1, 8'hff, {8{8'd10}}, 79, "R4");
    // R1: no spikes, large weights -> 0
    fixed_neuron(2, 8'h00, {8{8'd127}}, -1, "R1");
    fixed_neuron(2, 8'h00, {8{8'd127}}, 0, "R1");
    // R1: only lane 4 spikes, weight 50
    fixed_neuron(1, 8'h10, {24'hffffff, 8'd50, 32'h7f7f7f7f}, 49, "R1");
    fixed_neuron(1, 8'h10, {24'hffffff, 8'd50, 32'h7f7f7f7f}, 50, "R1");
    // R2/R10: negative full scale, 3 beats -> -3072
    fixed_neuron(3, 8'hff, {8{8'h80}}, -3073, "R10");
    fixed_neuron(3, 8'hff, {8{8'h80}}, -3072, "R2");
    // R9: big positive neuron followed by a small one
    fixed_neuron(4, 8'hff, {8{8'd100}}, 0, "R9");
    fixed_neuron(1, 8'h01, 64'h0000_0000_0000_0001, 1, "R9");
    // R6: disabled beats between beats of one neuron
    drive(1, 1, 0, 8'h03, 64'h0000_0000_0000_0505, 0, 0, "");
    drive(0, 1, 1, 8'hff, {8{8'd127}}, -5000, 0, "");
    drive(0, 0, 0, 8'hff, {8{8'h80}}, 0, 0, "");
    drive(1, 0, 1, 8'h01, 64'h0000_0000_0000_0002, 11, 1, "R6");
    drive(1, 1, 1, 8'h01, 64'h0000_0000_0000_0004, 4, 0, "R6");
    idle(3);
    // R10: 512 beats at full positive scale -> 520192
    fixed_neuron(512, 8'hff, {8{8'd127}}, 520191, "R10");
    fixed_neuron(512, 8'hff, {8{8'd127}}, 520192, "R10");
    idle(2);

    for (int n = 0; n < 300; n++) begin
      rand_neuron(1 + int'($urandom % 9), n % 2 == 1);
      if ($urandom % 5 == 0) idle(1 + int'($urandom % 3));
    end
    idle(LAT + 3);
    check(due_q.size() == 0, "R5", "pending results", due_q.size(), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R5 watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule